// File: doc/BRIEF.md
# Polling Active Exit Evaluator

This block watches the active polling substate of serial link training across a parameterised number of lanes. The transmit side reports each training set of type 1 it sends, and the per-lane receive decoders report each training set they accept, along with its type, whether its link-number and lane-number fields carried the PAD symbol, and two flags decoded from symbol 5. From these inputs the block decides when the link may move on to the configuration substate. It also detects when the substate has run too long and the link must drop back to detection.

There are two exit paths. The normal path needs enough sent training sets and an unbroken run of qualifying received sets on every detected lane. The fallback path opens once a millisecond timeout expires. It accepts a single good lane, provided enough training sets were sent after the first received type-1 set. While the substate is active, the block also tells the transmit side to place PAD in both number fields, and it always presents a fixed rate-support field taken from a parameter.

Top module: `poll_exit_eval`

## Requirements
- R1: After reset, `state` is 0 (idle), `advance` and `timeout_fail` are low, and `tx_pad_fields` is low.
- R2: A `start` pulse moves `state` to 1 (active) on the next cycle and clears all counts, runs and the timer. `tx_pad_fields` is high exactly while `state` is 1, and `tx_rate_adv` always equals the `RATE_SUPPORT` parameter.
- R3: A received set qualifies only if its link field and its lane field are both PAD (`rx_link_pad` = 1, `rx_lane_pad` = 1) and one of these holds:
  - it is a TS2 (`rx_ts2` = 1);
  - it is a TS1 with Compliance Receive (symbol 5 bit 4, `rx_compl_rx`) = 0;
  - it is a TS1 with Loopback (symbol 5 bit 2, `rx_loopbk`) = 1.
- R4: Each lane keeps a run of consecutive qualifying sets. The run returns to 0 on any received set that does not qualify, and it saturates at 8, so it never wraps.
- R5: When at least 1024 TS1s have been sent since `start` and every detected lane holds a run of 8, `advance` pulses. The pulse comes in the cycle after the input that completes the condition, and `state` then becomes 2.
- R6: Lanes whose `lane_mask` bit is 0 are ignored by both the all-lanes test and the any-lane test. With an empty mask the normal exit never fires.
- R7: The timeout expires on the 24th `ms_tick` counted while active. Before that, no timeout action is taken.
- R8: Once the timeout has expired, `advance` pulses if any detected lane holds a run of 8 and at least 1024 TS1s have been sent since the first TS1 was received on a detected lane. A send in the same cycle as that first TS1 counts.
- R9: If the timeout expires and neither exit condition holds, `timeout_fail` pulses for one cycle and `state` becomes 3 (back to detection).
- R10: `advance` and `timeout_fail` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Enter the active polling substate |
| lane_mask | input | NLANE | Lanes found present during detection |
| ts1_sent | input | 1 | One TS1 transmitted this cycle |
| ms_tick | input | 1 | One-millisecond tick |
| rx_valid | input | NLANE | Received set strobe per lane |
| rx_ts2 | input | NLANE | Received set is TS2 (0 = TS1) |
| rx_link_pad | input | NLANE | Link number field was PAD |
| rx_lane_pad | input | NLANE | Lane number field was PAD |
| rx_compl_rx | input | NLANE | Symbol 5 bit 4 of received set |
| rx_loopbk | input | NLANE | Symbol 5 bit 2 of received set |
| advance | output | 1 | Pulse: move to configuration |
| timeout_fail | output | 1 | Pulse: timeout without exit, back to detection |
| state | output | 2 | 0 idle, 1 active, 2 advanced, 3 failed |
| tx_pad_fields | output | 1 | Transmit PAD in link and lane numbers |
| tx_rate_adv | output | RATE_W | Advertised data-rate support |

## Verification
A lane run that fails to reset on a bad set shows up as an `advance` that comes early, in the same cycle as the set that should have completed the run. A wrapping run counter shows up instead as a missing `advance` once the send count completes. A sent-count or post-receive count that is off by one moves the `advance` pulse by one cycle, or turns a fallback exit into `timeout_fail` at the 24th tick. The scoreboard therefore pins every event to an exact cycle. Leaks from undetected lanes or from an empty mask appear as unexpected events while nothing is queued.

// File: rtl/pae_pkg.sv
package pae_pkg;
  typedef enum logic [1:0] {
    PST_IDLE   = 2'd0,
    PST_ACTIVE = 2'd1,
    PST_CONFIG = 2'd2,
    PST_DETECT = 2'd3
  } pst_e;
endpackage

// File: rtl/pae_sat_cnt.sv
// Saturating up-counter with synchronous clear; done when LIMIT reached.
module pae_sat_cnt #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | (inc & (cnt_q != TOP));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == TOP);
endmodule

// File: rtl/pae_lane_run.sv
// Per-lane qualification of received training sets and run tracking.
module pae_lane_run #(
  parameter int unsigned RUN_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic valid,
  input  logic is_ts2,
  input  logic link_pad,
  input  logic lane_pad,
  input  logic compl_rx,
  input  logic loopbk,
  output logic run_ok,
  output logic ts1_seen
);
  logic pad_ok, qual, take, bad;

  assign pad_ok   = link_pad & lane_pad;
  assign qual     = pad_ok & (is_ts2 | ~compl_rx | loopbk);
  assign take     = en & valid;
  assign bad      = take & ~qual;
  assign ts1_seen = take & ~is_ts2;

  pae_sat_cnt #(.LIMIT(RUN_MIN)) u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr | bad),
    .inc  (take & qual),
    .done (run_ok)
  );
endmodule

// File: rtl/poll_exit_eval.sv
module poll_exit_eval
  import pae_pkg::*;
#(
  parameter int unsigned NLANE   = 4,
  parameter int unsigned TX_MIN  = 1024,
  parameter int unsigned RUN_MIN = 8,
  parameter int unsigned TMO_MS  = 24,
  parameter int unsigned RATE_W  = 5,
  parameter logic [RATE_W-1:0] RATE_SUPPORT = 5'b00111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NLANE-1:0]  lane_mask,
  input  logic              ts1_sent,
  input  logic              ms_tick,
  input  logic [NLANE-1:0]  rx_valid,
  input  logic [NLANE-1:0]  rx_ts2,
  input  logic [NLANE-1:0]  rx_link_pad,
  input  logic [NLANE-1:0]  rx_lane_pad,
  input  logic [NLANE-1:0]  rx_compl_rx,
  input  logic [NLANE-1:0]  rx_loopbk,
  output logic              advance,
  output logic              timeout_fail,
  output logic [1:0]        state,
  output logic              tx_pad_fields,
  output logic [RATE_W-1:0] tx_rate_adv
);
  pst_e state_q, state_d;
  logic run_en;
  logic [NLANE-1:0] lane_ok, lane_ts1;
  logic seen_q, seen_d, seen_now;
  logic tx_done, post_done, tmo_done;
  logic all_ok, any_ok, go_normal, go_fb, go_exit;

  assign run_en = (state_q == PST_ACTIVE) & ~start;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pae_lane_run #(.RUN_MIN(RUN_MIN)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .en      (run_en & lane_mask[g]),
      .valid   (rx_valid[g]),
      .is_ts2  (rx_ts2[g]),
      .link_pad(rx_link_pad[g]),
      .lane_pad(rx_lane_pad[g]),
      .compl_rx(rx_compl_rx[g]),
      .loopbk  (rx_loopbk[g]),
      .run_ok  (lane_ok[g]),
      .ts1_seen(lane_ts1[g])
    );
  end

  assign seen_now = |lane_ts1;

  always_comb begin
    seen_d = seen_q;
    if (start)         seen_d = 1'b0;
    else if (seen_now) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  pae_sat_cnt #(.LIMIT(TX_MIN)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(run_en & ts1_sent), .done(tx_done)
  );

  pae_sat_cnt #(.LIMIT(TX_MIN)) u_post_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(run_en & ts1_sent & (seen_q | seen_now)), .done(post_done)
  );

  pae_sat_cnt #(.LIMIT(TMO_MS)) u_ms_timer (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(run_en & ms_tick), .done(tmo_done)
  );

  assign all_ok    = (|lane_mask) & (&(lane_ok | ~lane_mask));
  assign any_ok    = |(lane_ok & lane_mask);
  assign go_normal = tx_done & all_ok;
  assign go_fb     = tmo_done & post_done & any_ok;
  assign go_exit   = go_normal | go_fb;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PST_ACTIVE: begin
        if (start)         state_d = PST_ACTIVE;
        else if (go_exit)  state_d = PST_CONFIG;
        else if (tmo_done) state_d = PST_DETECT;
      end
      default: if (start) state_d = PST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PST_IDLE;
    else        state_q <= state_d;
  end

  assign advance       = run_en & go_exit;
  assign timeout_fail  = run_en & tmo_done & ~go_exit;
  assign state         = state_q;
  assign tx_pad_fields = (state_q == PST_ACTIVE);
  assign tx_rate_adv   = RATE_SUPPORT;
endmodule

// File: rtl/pae_checker.sv
module pae_checker #(
  parameter int unsigned TX_MIN = 1024,
  parameter int unsigned TMO_MS = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ts1_sent,
  input logic       ms_tick,
  input logic       advance,
  input logic       timeout_fail,
  input logic [1:0] state
);
  logic [31:0] sent_q, tick_q;
  logic        act;

  assign act = (state == 2'd1) & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      tick_q <= '0;
    end else if (start) begin
      sent_q <= '0;
      tick_q <= '0;
    end else begin
      if (act && ts1_sent && sent_q < TX_MIN) sent_q <= sent_q + 1;
      if (act && ms_tick && tick_q < TMO_MS)  tick_q <= tick_q + 1;
    end
  end

  p_start_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state == 2'd1);
  p_adv_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> sent_q == TX_MIN);
  p_adv_config_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> state == 2'd2);
  p_fail_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fail |-> tick_q == TMO_MS);
  p_fail_detect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fail |=> state == 2'd3);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && timeout_fail));
  p_adv_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> !advance);
endmodule

bind poll_exit_eval pae_checker #(.TX_MIN(TX_MIN), .TMO_MS(TMO_MS)) u_pae_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ts1_sent(ts1_sent),
  .ms_tick(ms_tick), .advance(advance), .timeout_fail(timeout_fail),
  .state(state)
);

// File: tb/tb_poll_exit_eval.sv
module tb_poll_exit_eval;
  localparam int NL = 4;
  localparam logic [4:0] RATES = 5'b00111;

  logic clk = 1'b0;
  logic rst_n;
  logic start, ts1_sent, ms_tick;
  logic [NL-1:0] lane_mask, rx_valid, rx_ts2, rx_link_pad, rx_lane_pad, rx_compl_rx, rx_loopbk;
  logic advance, timeout_fail, tx_pad_fields;
  logic [1:0] state;
  logic [4:0] tx_rate_adv;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { int kind; int at; string req; } evt_t;
  evt_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  poll_exit_eval dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mask(lane_mask),
    .ts1_sent(ts1_sent), .ms_tick(ms_tick), .rx_valid(rx_valid),
    .rx_ts2(rx_ts2), .rx_link_pad(rx_link_pad), .rx_lane_pad(rx_lane_pad),
    .rx_compl_rx(rx_compl_rx), .rx_loopbk(rx_loopbk), .advance(advance),
    .timeout_fail(timeout_fail), .state(state), .tx_pad_fields(tx_pad_fields),
    .tx_rate_adv(tx_rate_adv)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every event
  always @(negedge clk) begin
    if (rst_n && (advance || timeout_fail)) begin
      chk(!(advance && timeout_fail), "R10 both", 1, 0);
      if (q.size() == 0) begin
        chk(0, "R10 unexpected event", cyc, -1);
      end else begin
        evt_t e;
        e = q.pop_front();
        chk(e.kind == (timeout_fail ? 1 : 0), e.req, timeout_fail ? 1 : 0, e.kind);
        chk(e.at == cyc, e.req, cyc, e.at);
      end
    end
  end

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_evt(int kind, string req);
    evt_t e;
    e.kind = kind;
    e.at   = cyc;
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic rx_clr();
    rx_valid = '0; rx_ts2 = '0; rx_link_pad = '0;
    rx_lane_pad = '0; rx_compl_rx = '0; rx_loopbk = '0;
  endtask

  task automatic rx_set(int ln, bit t2, bit lp, bit np, bit cr, bit lb);
    rx_valid[ln] = 1'b1; rx_ts2[ln] = t2; rx_link_pad[ln] = lp;
    rx_lane_pad[ln] = np; rx_compl_rx[ln] = cr; rx_loopbk[ln] = lb;
  endtask

  task automatic good(int ln, int n);
    for (int i = 0; i < n; i++) begin
      rx_set(ln, 0, 1, 1, 0, 0);
      nxt();
      rx_clr();
    end
  endtask

  task automatic send(int n);
    ts1_sent = 1'b1;
    repeat (n) nxt();
    ts1_sent = 1'b0;
  endtask

  task automatic ticks(int n);
    ms_tick = 1'b1;
    repeat (n) nxt();
    ms_tick = 1'b0;
  endtask

  task automatic enter(logic [NL-1:0] m);
    lane_mask = m;
    start = 1'b1;
    nxt();
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; ts1_sent = 0; ms_tick = 0; lane_mask = '0;
    rx_clr();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(state == 2'd0, "R1 state", state, 0);
    chk(!advance && !timeout_fail, "R1 events", advance, 0);
    chk(!tx_pad_fields, "R1 pad", tx_pad_fields, 0);
    chk(tx_rate_adv == RATES, "R2 rates", tx_rate_adv, RATES);

    // R2 + R3 + R5: mixed qualifying forms on all lanes, sends complete last
    enter(4'b1111);
    chk(state == 2'd1, "R2 active", state, 1);
    chk(tx_pad_fields, "R2 pad active", tx_pad_fields, 1);
    for (int i = 0; i < 8; i++) begin
      rx_set(0, 0, 1, 1, 0, 0);
      rx_set(1, 0, 1, 1, 1, 1);
      rx_set(2, 1, 1, 1, 1, 0);
      rx_set(3, 0, 1, 1, 0, 1);
      nxt();
      rx_clr();
    end
    send(1023);
    chk(state == 2'd1, "R5 1023 sent", state, 1);
    send(1);
    expect_evt(0, "R5 normal exit");
    nxt();
    chk(state == 2'd2, "R5 config", state, 2);
    chk(!tx_pad_fields, "R2 pad off", tx_pad_fields, 0);

    // R4: bad set breaks lane 0 run
    enter(4'b0011);
    send(1024);
    for (int i = 0; i < 7; i++) begin
      rx_set(0, 0, 1, 1, 0, 0); rx_set(1, 0, 1, 1, 0, 0); nxt(); rx_clr();
    end
    rx_set(0, 0, 1, 1, 1, 0); rx_set(1, 0, 1, 1, 0, 0); nxt(); rx_clr();
    good(0, 7);
    chk(state == 2'd1, "R4 run reset", state, 1);
    good(0, 1);
    expect_evt(0, "R4 run restart");
    nxt();

    // R3: TS2 with non-PAD link field is not qualifying
    enter(4'b0001);
    good(0, 7);
    rx_set(0, 1, 0, 1, 0, 0); nxt(); rx_clr();
    good(0, 7);
    send(1024);
    chk(state == 2'd1, "R3 nonpad link", state, 1);
    good(0, 1);
    expect_evt(0, "R3 after nonpad");
    nxt();

    // R6: undetected lanes carrying bad sets are ignored
    enter(4'b0101);
    send(1024);
    for (int i = 0; i < 8; i++) begin
      rx_set(0, 0, 1, 1, 0, 0); rx_set(2, 1, 1, 1, 0, 0);
      rx_set(1, 0, 0, 0, 1, 0); rx_set(3, 0, 1, 1, 1, 0);
      nxt(); rx_clr();
    end
    expect_evt(0, "R6 masked lanes");
    nxt();

    // R4 saturation + R7 + R8 fallback on one lane
    enter(4'b0011);
    good(0, 12);
    send(1024);
    ticks(23);
    chk(state == 2'd1, "R7 before timeout", state, 1);
    ticks(1);
    expect_evt(0, "R8 fallback exit");
    nxt();
    chk(state == 2'd2, "R8 config", state, 2);

    // R9: sends all before any received TS1 -> timeout fail
    enter(4'b0011);
    send(1024);
    good(0, 8);
    ticks(24);
    expect_evt(1, "R9 fail no post sends");
    nxt();
    chk(state == 2'd3, "R9 detect", state, 3);

    // R8 boundary: 1023 sends after first received TS1 is not enough
    enter(4'b0011);
    good(0, 8);
    send(1023);
    ticks(24);
    expect_evt(1, "R8 1023 post sends");
    nxt();

    // R6 empty mask: no exit, timeout fails
    enter(4'b0000);
    good(0, 8);
    send(1024);
    chk(state == 2'd1, "R6 empty mask", state, 1);
    ticks(24);
    expect_evt(1, "R6 empty mask fail");
    nxt();

    repeat (3) nxt();
    chk(q.size() == 0, "R10 pending events", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule